// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral with sixteen-bit registers behind a plain synchronous write-strobe bus with combinational reads. A prescaler divides the system clock into a fixed 0.6-second tick. A ten-bit down-counter runs on that tick, from an initial value that software programs. Software services the watchdog by writing to the reload register, which puts the programmed value back into the counter.

The first time the counter runs out, the block sets a first-timeout status flag. If software has enabled it, the block also raises an interrupt request. The counter then reloads and keeps running. If it runs out a second time while that flag is still set, the block sets two second-stage status flags and stops counting. It also drives a system-reset pulse of fixed length, unless the no-reboot configuration bit holds the pulse back. Clearing the first-timeout flag between the two expiries starts the two-stage sequence again.

Top module: `wdt_top`

## Requirements
- R1: After reset the count and the initial value are both INIT_DEF (default 4). The control register reads 0x0800, which means halted. Both status registers, the configuration register and the interrupt-enable register read 0, and irq_o and sys_rst_o are low.
- R2: The halt bit sits at bit 11 of the control register (address 4). While it is 0, the count drops by one every PRESCALE = CLK_HZ*TICK_MS/1000 clock cycles, counted from the write that cleared the bit or from the last reload. While it is 1, the count holds.
- R3: A write of any data to address 0 sets the count to the stored initial value and restarts the prescaler phase. A read of address 0 returns the live count in bits 9:0, with bits 15:10 reading 0.
- R4: A write to the initial-value register (address 1) stores only bits 9:0 of the data. Bits 15:10 always read 0.
- R5: A write to address 1 whose bits 9:0 hold a value from 0 to 3 leaves the stored initial value unchanged.
- R6: The tick that finds the count at 0 while bit 3 of status register 1 (address 2) is clear is the first expiry. It sets that bit and reloads the count from the initial value, and counting goes on. Writing 1 to that bit clears it.
- R7: The tick that finds the count at 0 while status bit 3 is set is the second expiry. It sets bit 1 (second timeout) and bit 2 (boot status) of status register 2 (address 3), and both bits are write-1-to-clear. It also drives sys_rst_o high for exactly RST_PULSE cycles, starting in the cycle after the expiry edge. From then on the counter stays frozen until the block is reset. If software clears bit 3 before the counter next reaches 0, that expiry is treated as a first expiry again.
- R8: Bit 0 of the configuration register (address 5) is the no-reboot bit, and it reads back as written. While it is 1, a second expiry still sets the second-stage status bits and stops the counter, but sys_rst_o stays low.
- R9: irq_o is high exactly while status bit 3 is set and bit 13 of the interrupt-enable register (address 6) is 1.
- R10: When a write-1-to-clear of a status bit falls in the same cycle as the hardware event that sets that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | First-timeout interrupt request |
| sys_rst_o | output | 1 | System-reset pulse request |

## Verification
The bench builds the block with CLK_HZ=10 and TICK_MS=600, which gives a six-cycle tick, and with RST_PULSE=4. With these values, a full two-stage run of small initial values takes only a few dozen cycles. That makes it practical to check the count after every tick and at mid-tick, and to land a write exactly on an expiry edge. The bench sweeps every initial-value write from 0 to 15, with the upper bits set, against an arithmetic model of the stored value. It times both stages for initial values 5 and 4, and it measures the reset pulse width cycle by cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W  = 10;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int NREG   = 7;

    localparam logic [CNT_W-1:0] MIN_INIT = CNT_W'(4);

    // Register word addresses
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_INIT  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STS1  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_STS2  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(6);

    // Bit positions inside registers
    localparam int B_HALT   = 11;
    localparam int B_FIRST  = 3;
    localparam int B_SECOND = 1;
    localparam int B_BOOT   = 2;
    localparam int B_NOREB  = 0;
    localparam int B_IEN    = 13;

    typedef struct packed {
        logic             halt;
        logic             no_reboot;
        logic             ien;
        logic [CNT_W-1:0] init;
    } wdt_ctl_t;

    typedef struct packed {
        logic first;
        logic second;
    } wdt_evt_t;

    function automatic int unsigned prescale_cycles(input longint unsigned clk_hz,
                                                    input longint unsigned tick_ms);
        longint unsigned c;
        c = (clk_hz * tick_ms) / 64'd1000;
        if (c < 64'd2) c = 64'd2;
        return c[31:0];
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int unsigned PRESCALE = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] phase_q;

    assign tick = run && !restart && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned     RST_PULSE = 16,
    parameter logic [CNT_W-1:0] INIT_DEF = CNT_W'(4)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload,
    input  wdt_ctl_t         ctl,
    input  logic             first_sts,
    output logic [CNT_W-1:0] cnt,
    output wdt_evt_t         evt,
    output logic             run,
    output logic             sys_rst
);
    localparam int RW = $clog2(RST_PULSE + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             stopped_q;
    logic [RW-1:0]    pulse_q;
    logic             expire;

    assign expire     = tick && !reload && (cnt_q == '0);
    assign evt.first  = expire && !first_sts;
    assign evt.second = expire && first_sts;
    assign run        = !ctl.halt && !stopped_q;
    assign cnt        = cnt_q;
    assign sys_rst    = (pulse_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= INIT_DEF;
            stopped_q <= 1'b0;
        end else begin
            if (reload || expire) begin
                cnt_q <= ctl.init;
            end else if (tick) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (evt.second) begin
                stopped_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
        end else if (evt.second && !ctl.no_reboot) begin
            pulse_q <= RW'(RST_PULSE);
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter logic [CNT_W-1:0] INIT_DEF = CNT_W'(4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  wdt_evt_t          evt,
    output wdt_ctl_t          ctl,
    output logic              first_sts,
    output logic              second_sts,
    output logic              boot_sts,
    output logic              reload
);
    logic [NREG-1:0] wsel;

    for (genvar i = 0; i < NREG; i++) begin : g_wsel
        assign wsel[i] = bus_wr && (bus_addr == ADDR_W'(i));
    end

    assign reload = wsel[A_COUNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.halt      <= 1'b1;
            ctl.no_reboot <= 1'b0;
            ctl.ien       <= 1'b0;
            ctl.init      <= INIT_DEF;
            first_sts     <= 1'b0;
            second_sts    <= 1'b0;
            boot_sts      <= 1'b0;
        end else begin
            if (wsel[A_INIT] && (bus_wdata[CNT_W-1:0] >= MIN_INIT)) begin
                ctl.init <= bus_wdata[CNT_W-1:0];
            end
            if (wsel[A_CTRL]) ctl.halt      <= bus_wdata[B_HALT];
            if (wsel[A_CFG])  ctl.no_reboot <= bus_wdata[B_NOREB];
            if (wsel[A_IEN])  ctl.ien       <= bus_wdata[B_IEN];
            first_sts  <= (first_sts  && !(wsel[A_STS1] && bus_wdata[B_FIRST]))  || evt.first;
            second_sts <= (second_sts && !(wsel[A_STS2] && bus_wdata[B_SECOND])) || evt.second;
            boot_sts   <= (boot_sts   && !(wsel[A_STS2] && bus_wdata[B_BOOT]))   || evt.second;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_COUNT: bus_rdata[CNT_W-1:0] = cnt;
            A_INIT:  bus_rdata[CNT_W-1:0] = ctl.init;
            A_STS1:  bus_rdata[B_FIRST]   = first_sts;
            A_STS2: begin
                bus_rdata[B_SECOND] = second_sts;
                bus_rdata[B_BOOT]   = boot_sts;
            end
            A_CTRL:  bus_rdata[B_HALT]  = ctl.halt;
            A_CFG:   bus_rdata[B_NOREB] = ctl.no_reboot;
            A_IEN:   bus_rdata[B_IEN]   = ctl.ien;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned     TICK_MS   = 600,
    parameter int unsigned     RST_PULSE = 16,
    parameter int unsigned     INIT_DEF  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    localparam int unsigned      PRESCALE = prescale_cycles(CLK_HZ, 64'(TICK_MS));
    localparam logic [CNT_W-1:0] INIT_V   = CNT_W'(INIT_DEF);

    wdt_ctl_t         ctl;
    wdt_evt_t         evt;
    logic [CNT_W-1:0] cnt;
    logic             first_sts, second_sts, boot_sts;
    logic             reload, run, tick;

    wdt_regs #(.INIT_DEF(INIT_V)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt        (cnt),
        .evt        (evt),
        .ctl        (ctl),
        .first_sts  (first_sts),
        .second_sts (second_sts),
        .boot_sts   (boot_sts),
        .reload     (reload)
    );

    wdt_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (reload),
        .tick    (tick)
    );

    wdt_core #(.RST_PULSE(RST_PULSE), .INIT_DEF(INIT_V)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .reload    (reload),
        .ctl       (ctl),
        .first_sts (first_sts),
        .cnt       (cnt),
        .evt       (evt),
        .run       (run),
        .sys_rst   (sys_rst_o)
    );

    assign irq_o = first_sts && ctl.ien;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int unsigned RST_PULSE = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             reload,
    input logic             halt,
    input logic             no_reboot,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] init,
    input logic             first_sts,
    input logic             second_sts,
    input logic             boot_sts,
    input logic             sys_rst
);
    localparam int WW = $clog2(RST_PULSE + 2);
    logic [WW-1:0] width_q;

    always_ff @(posedge clk) begin
        if (rst) width_q <= '0;
        else if (sys_rst) width_q <= width_q + 1'b1;
        else width_q <= '0;
    end

    always_comb begin
        if (!rst) begin
            a_r5_init_floor: assert (init >= MIN_INIT);
        end
    end

    a_r2_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (halt && !reload) |=> $stable(cnt));

    a_r6_first_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(first_sts) |-> $past(tick && cnt == '0));

    a_r7_second_flags: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |-> (second_sts && boot_sts));

    a_r7_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst) |-> (width_q == WW'(RST_PULSE)));

    a_r7_pulse_bound: assert property (@(posedge clk) disable iff (rst)
        width_q <= WW'(RST_PULSE));

    a_r8_suppress: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |-> !$past(no_reboot));
endmodule

bind wdt_top wdt_checker #(.RST_PULSE(RST_PULSE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .reload     (reload),
    .halt       (ctl.halt),
    .no_reboot  (ctl.no_reboot),
    .cnt        (cnt),
    .init       (ctl.init),
    .first_sts  (first_sts),
    .second_sts (second_sts),
    .boot_sts   (boot_sts),
    .sys_rst    (sys_rst_o)
);

// File: tb/test_wdt_top.sv
module test_wdt_top;
    localparam int P  = 6;   // 10 Hz * 600 ms / 1000
    localparam int RP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq_o, sys_rst_o;

    int checks = 0;
    int errors = 0;
    int rst_seen = 0;

    always #5 clk = ~clk;

    wdt_top #(.CLK_HZ(10), .TICK_MS(600), .RST_PULSE(RP), .INIT_DEF(4)) i_wdt_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    always @(negedge clk) if (sys_rst_o) rst_seen++;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v, hold;
        int prev, rs0;
        @(negedge clk);
        do_reset;

        // R1 reset state
        rd(3'd0, v); chk("R1 count", v, 16'd4);
        rd(3'd1, v); chk("R1 init", v, 16'd4);
        rd(3'd4, v); chk("R1 ctrl", v, 16'h0800);
        rd(3'd2, v); chk("R1 sts1", v, 16'd0);
        rd(3'd3, v); chk("R1 sts2", v, 16'd0);
        rd(3'd5, v); chk("R1 cfg", v, 16'd0);
        rd(3'd6, v); chk("R1 ien", v, 16'd0);
        chk("R1 irq", {15'd0, irq_o}, 16'd0);
        chk("R1 sysrst", {15'd0, sys_rst_o}, 16'd0);

        // R4 / R5 sweep of initial-value writes with upper bits set
        prev = 4;
        for (int i = 0; i < 16; i++) begin
            wr(3'd1, 16'hFC00 | 16'(i));
            if (i >= 4) prev = i;
            rd(3'd1, v);
            chk((i < 4) ? "R5 ignore low init" : "R4 init field", v, 16'(prev));
        end
        wr(3'd1, 16'd5);

        // R3 reload while halted, R2 hold while halted
        wr(3'd0, 16'hBEEF);
        rd(3'd0, v); chk("R3 reload value", v, 16'd5);
        wait_n(20);
        rd(3'd0, v); chk("R2 halted hold", v, 16'd5);

        // R2 countdown per tick
        wr(3'd4, 16'h0000);
        wait_n(P - 1);
        rd(3'd0, v); chk("R2 mid tick", v, 16'd5);
        wait_n(1);
        rd(3'd0, v); chk("R2 tick 1", v, 16'd4);
        for (int k = 2; k <= 5; k++) begin
            wait_n(P);
            rd(3'd0, v); chk("R2 tick k", v, 16'(5 - k));
        end
        wait_n(P);
        rd(3'd2, v); chk("R6 first expiry", v, 16'h0008);
        rd(3'd0, v); chk("R6 reload on expiry", v, 16'd5);
        rd(3'd3, v); chk("R6 no second flags", v, 16'd0);
        chk("R9 irq masked", {15'd0, irq_o}, 16'd0);

        // R9 interrupt gate
        wr(3'd6, 16'h2000);
        chk("R9 irq on", {15'd0, irq_o}, 16'd1);
        wr(3'd6, 16'h0000);
        chk("R9 irq off", {15'd0, irq_o}, 16'd0);
        wr(3'd6, 16'h2000);

        // R6 write-1-to-clear
        wr(3'd2, 16'h0008);
        rd(3'd2, v); chk("R6 w1c", v, 16'd0);
        chk("R9 irq follows clear", {15'd0, irq_o}, 16'd0);

        // R7 clearing between expiries restarts the sequence
        wr(3'd0, 16'd0);
        wait_n(6 * P);
        rd(3'd2, v); chk("R6 expiry again", v, 16'h0008);
        chk("R9 irq set", {15'd0, irq_o}, 16'd1);
        wr(3'd2, 16'h0008);
        wait_n(6 * P - 1);
        rd(3'd2, v); chk("R7 cleared -> first again", v, 16'h0008);
        rd(3'd3, v); chk("R7 no second flags", v, 16'd0);
        chk("R7 no pulse", 16'(rst_seen), 16'd0);

        // R10 set wins over clear in the same cycle
        wr(3'd2, 16'h0008);
        wr(3'd0, 16'd0);
        wait_n(6 * P - 1);
        wr(3'd2, 16'h0008);
        rd(3'd2, v); chk("R10 set priority", v, 16'h0008);

        // R7 second expiry and reset pulse
        wait_n(6 * P - 1);
        chk("R7 pulse not yet", {15'd0, sys_rst_o}, 16'd0);
        rd(3'd3, v); chk("R7 sts2 not yet", v, 16'd0);
        wait_n(1);
        chk("R7 pulse start", {15'd0, sys_rst_o}, 16'd1);
        rd(3'd3, v); chk("R7 sts2 set", v, 16'h0006);
        wait_n(RP - 1);
        chk("R7 pulse end-1", {15'd0, sys_rst_o}, 16'd1);
        wait_n(1);
        chk("R7 pulse done", {15'd0, sys_rst_o}, 16'd0);
        chk("R7 pulse width", 16'(rst_seen), 16'(RP));
        rd(3'd0, hold);
        wait_n(5 * P);
        rd(3'd0, v); chk("R7 frozen", v, hold);
        wr(3'd3, 16'h0002);
        rd(3'd3, v); chk("R7 w1c second", v, 16'h0004);
        wr(3'd3, 16'h0004);
        rd(3'd3, v); chk("R7 w1c boot", v, 16'h0000);

        // R8 no-reboot suppression with initial value 4
        do_reset;
        rs0 = rst_seen;
        wr(3'd5, 16'h0001);
        rd(3'd5, v); chk("R8 readback", v, 16'h0001);
        wr(3'd1, 16'd4);
        wr(3'd4, 16'h0000);
        wait_n(5 * P);
        rd(3'd2, v); chk("R8 first expiry n4", v, 16'h0008);
        wait_n(5 * P);
        rd(3'd3, v); chk("R8 second flags", v, 16'h0006);
        wait_n(RP + 2);
        chk("R8 pulse suppressed", 16'(rst_seen - rs0), 16'd0);
        rd(3'd0, hold);
        wait_n(3 * P);
        rd(3'd0, v); chk("R8 frozen", v, hold);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule